// File: doc/BRIEF.md
# Integer Condition Code Register

This block holds the eight status flags of a combined integer and floating-point arithmetic unit. Each accepted operation is marked by an op-valid strobe. For integer add, subtract, shift and rotate operations, and for address-unit update operations, the block derives carry, overflow, zero and negative from the operands, the result and the adder's carry-out. For floating-point operations, it loads four floating-point status flags from an external input.

Floating-point operations keep the carry flag. They change the overflow flag only when they yield a fixed-point result. A data-bus transfer indicator blocks every update, so moves over the buses never change a flag. With no strobe, the register keeps its value.

Top module: `ccr_unit`

## Requirements
- R1: After reset, every bit of `ccr` is 0. The bit layout is: [0] carry, [1] overflow, [2] zero, [3] negative, [4] infinity, [5] local reject, [6] reject, [7] accept.
- R2: For an add (`op_class`=0), carry takes `alu_cout`. Overflow is set when both operands share a sign and the result's sign differs from it.
- R3: For a subtract a-b (`op_class`=1), carry takes `alu_cout`, which carries the borrow out of the top bit. Overflow is set when the operand signs differ and the result's sign differs from that of a.
- R4: For the single-bit shifts and rotates, overflow is cleared and carry takes the bit moved out. The classes are shift left (2), logical shift right (3), rotate left (4) and rotate right (5). Left moves take a's top bit and right moves take a's bit 0.
- R5: On every accepted operation, zero is set exactly when `result` is all zeros, and negative copies the top bit of `result`.
- R6: A floating-point operation (`op_class`=6) leaves carry unchanged and loads bits [7:4] from `fp_status`.
- R7: A floating-point operation leaves overflow unchanged when `fp_fixed` is 0. When `fp_fixed` is 1, it loads overflow from `fp_fix_ovf`.
- R8: An address-unit update (`op_class`=7) sets carry, overflow, zero and negative by the add rules.
- R9: While `bus_xfer` is 1, no flag changes, even with `op_valid` high.
- R10: With `op_valid` low, the register holds its value.
- R11: Integer and address-unit operations leave bits [7:4] unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation completes this cycle |
| bus_xfer | input | 1 | Data-bus transfer in progress; blocks updates |
| op_class | input | 3 | Operation class code (see requirements) |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| result | input | W | Operation result |
| alu_cout | input | 1 | Carry or borrow out of the top bit |
| fp_fixed | input | 1 | Floating-point operation produced a fixed-point result |
| fp_fix_ovf | input | 1 | Overflow of that fixed-point result |
| fp_status | input | 4 | Floating-point flags {accept, reject, local reject, infinity} |
| ccr | output | 8 | The condition code register |

## Verification
Each integer class is driven with operand pairs chosen to separate the flags. Adds and subtracts are tried with and without carry or borrow, with signed overflow in both directions, and with results that are exactly zero, which shows whether carry and overflow are computed independently. Shifts and rotates use operands whose top and bottom bits differ, so taking the bit from the wrong end is visible. Directed sequences set carry first and then issue floating-point operations with and without a fixed-point result. They then repeat the operation with the transfer indicator or with the strobe removed, which exposes any flag that leaks through when it should be held.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  typedef enum logic [2:0] {
    OPC_ADD = 3'd0,
    OPC_SUB = 3'd1,
    OPC_SHL = 3'd2,
    OPC_SHR = 3'd3,
    OPC_ROL = 3'd4,
    OPC_ROR = 3'd5,
    OPC_FP  = 3'd6,
    OPC_AGU = 3'd7
  } opc_e;

  localparam int CCR_W    = 8;
  localparam int FPS_W    = 4;
  localparam int BIT_C    = 0;
  localparam int BIT_V    = 1;
  localparam int BIT_Z    = 2;
  localparam int BIT_N    = 3;
  localparam int FPS_LO   = 4;
endpackage

// File: rtl/ccr_carry_ovf.sv
module ccr_carry_ovf
  import ccr_pkg::*;
#(
  parameter int W = 32
) (
  input  opc_e         op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] res,
  input  logic         cout,
  input  logic         fp_fixed,
  input  logic         fp_fix_ovf,
  output logic         c_new,
  output logic         c_wr,
  output logic         v_new,
  output logic         v_wr
);
  localparam int MSB = W - 1;

  function automatic logic add_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    return (x[MSB] == y[MSB]) && (r[MSB] != x[MSB]);
  endfunction

  function automatic logic sub_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] r);
    return (x[MSB] != y[MSB]) && (r[MSB] != x[MSB]);
  endfunction

  function automatic logic moved_out(input opc_e o, input logic [W-1:0] x);
    return (o == OPC_SHL || o == OPC_ROL) ? x[MSB] : x[0];
  endfunction

  always_comb begin
    c_new = 1'b0;
    c_wr  = 1'b1;
    v_new = 1'b0;
    v_wr  = 1'b1;
    unique case (op)
      OPC_ADD, OPC_AGU: begin
        c_new = cout;
        v_new = add_ovf(a, b, res);
      end
      OPC_SUB: begin
        c_new = cout;
        v_new = sub_ovf(a, b, res);
      end
      OPC_SHL, OPC_SHR, OPC_ROL, OPC_ROR: begin
        c_new = moved_out(op, a);
        v_new = 1'b0;
      end
      OPC_FP: begin
        c_wr  = 1'b0;
        v_wr  = fp_fixed;
        v_new = fp_fix_ovf;
      end
      default: begin
        c_wr = 1'b0;
        v_wr = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ccr_zn.sv
module ccr_zn #(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  output logic         z,
  output logic         n
);
  function automatic logic all_zero(input logic [W-1:0] r);
    return ~|r;
  endfunction

  assign z = all_zero(res);
  assign n = res[W-1];
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             bus_xfer,
  input  logic [2:0]       op_class,
  input  logic [W-1:0]     opnd_a,
  input  logic [W-1:0]     opnd_b,
  input  logic [W-1:0]     result,
  input  logic             alu_cout,
  input  logic             fp_fixed,
  input  logic             fp_fix_ovf,
  input  logic [FPS_W-1:0] fp_status,
  output logic [CCR_W-1:0] ccr
);
  opc_e             op;
  logic             upd;
  logic             is_fp;
  logic             is_shift;
  logic             c_new, c_wr, v_new, v_wr;
  logic             z_new, n_new;
  logic [CCR_W-1:0] ccr_q, ccr_d;

  assign op       = opc_e'(op_class);
  assign upd      = op_valid && !bus_xfer;
  assign is_fp    = (op == OPC_FP);
  assign is_shift = (op == OPC_SHL) || (op == OPC_SHR) ||
                    (op == OPC_ROL) || (op == OPC_ROR);

  ccr_carry_ovf #(.W(W)) u_cv (
    .op(op), .a(opnd_a), .b(opnd_b), .res(result), .cout(alu_cout),
    .fp_fixed(fp_fixed), .fp_fix_ovf(fp_fix_ovf),
    .c_new(c_new), .c_wr(c_wr), .v_new(v_new), .v_wr(v_wr)
  );

  ccr_zn #(.W(W)) u_zn (.res(result), .z(z_new), .n(n_new));

  always_comb begin
    ccr_d = ccr_q;
    if (upd) begin
      if (c_wr) ccr_d[BIT_C] = c_new;
      if (v_wr) ccr_d[BIT_V] = v_new;
      ccr_d[BIT_Z] = z_new;
      ccr_d[BIT_N] = n_new;
      if (is_fp) ccr_d[CCR_W-1:FPS_LO] = fp_status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ccr_q <= '0;
    else        ccr_q <= ccr_d;
  end

  assign ccr = ccr_q;

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(ccr_q));

  a_r9_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    bus_xfer |=> $stable(ccr_q));

  a_r6_fp_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_fp) |=> ccr_q[BIT_C] == $past(ccr_q[BIT_C]));

  a_r7_fp_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_fp && !fp_fixed) |=> ccr_q[BIT_V] == $past(ccr_q[BIT_V]));

  a_r4_shift_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && is_shift) |=> !ccr_q[BIT_V]);

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ccr_q[BIT_Z] == ($past(result) == '0));

  a_r11_int_keeps_fp: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !is_fp) |=> $stable(ccr_q[CCR_W-1:FPS_LO]));

  a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && (op == OPC_ADD || op == OPC_SUB)) |=> ccr_q[BIT_C] == $past(alu_cout));
endmodule

// File: tb/ccr_unit_bench.sv
module ccr_unit_bench;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic          bus_xfer = 1'b0;
  logic [2:0]    op_class = 3'd0;
  logic [W-1:0]  opnd_a = '0;
  logic [W-1:0]  opnd_b = '0;
  logic [W-1:0]  result = '0;
  logic          alu_cout = 1'b0;
  logic          fp_fixed = 1'b0;
  logic          fp_fix_ovf = 1'b0;
  logic [3:0]    fp_status = 4'd0;
  logic [7:0]    ccr;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  ccr_unit #(.W(W)) u_ccr_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .bus_xfer(bus_xfer),
    .op_class(op_class), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .alu_cout(alu_cout), .fp_fixed(fp_fixed), .fp_fix_ovf(fp_fix_ovf),
    .fp_status(fp_status), .ccr(ccr)
  );

  // entry: {class, a, b, expected {N,Z,V,C}}
  localparam logic [70:0] VEC [18] = '{
    {3'd0, 32'h00000001, 32'h00000002, 4'b0000},  // R2 plain add
    {3'd0, 32'hFFFFFFFF, 32'h00000001, 4'b0101},  // R2 carry, zero
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 4'b1010},  // R2 positive overflow
    {3'd0, 32'h80000000, 32'h80000000, 4'b0111},  // R2 negative overflow
    {3'd1, 32'h00000005, 32'h00000003, 4'b0000},  // R3 plain sub
    {3'd1, 32'h00000003, 32'h00000005, 4'b1001},  // R3 borrow
    {3'd1, 32'h80000000, 32'h00000001, 4'b0010},  // R3 overflow
    {3'd1, 32'h00000007, 32'h00000007, 4'b0100},  // R3 zero
    {3'd2, 32'h80000001, 32'h00000000, 4'b0001},  // R4 shl out 1
    {3'd2, 32'h40000000, 32'h00000000, 4'b1000},  // R4 shl negative
    {3'd3, 32'h00000001, 32'h00000000, 4'b0101},  // R4 shr out 1
    {3'd3, 32'h80000000, 32'h00000000, 4'b0000},  // R4 shr out 0
    {3'd4, 32'h80000000, 32'h00000000, 4'b0001},  // R4 rol
    {3'd4, 32'h00000000, 32'h00000000, 4'b0100},  // R4 rol zero
    {3'd5, 32'h00000001, 32'h00000000, 4'b1001},  // R4 ror
    {3'd5, 32'h00000002, 32'h00000000, 4'b0000},  // R4 ror out 0
    {3'd7, 32'hFFFFFFF0, 32'h00000010, 4'b0101},  // R8 agu carry
    {3'd7, 32'h7FFFFFF0, 32'h00000010, 4'b1010}   // R8 agu overflow
  };

  // Model of the ALU feeding the block: result and carry/borrow.
  task automatic alu_model(input logic [2:0] cls, input logic [W-1:0] a,
                           input logic [W-1:0] b);
    logic [W:0] wide;
    wide = '0;
    case (cls)
      3'd0, 3'd7: begin wide = {1'b0, a} + {1'b0, b}; result = wide[W-1:0]; alu_cout = wide[W]; end
      3'd1: begin result = a - b; alu_cout = (a < b); end
      3'd2: begin result = a << 1; alu_cout = 1'b0; end
      3'd3: begin result = a >> 1; alu_cout = 1'b0; end
      3'd4: begin result = {a[W-2:0], a[W-1]}; alu_cout = 1'b0; end
      3'd5: begin result = {a[0], a[W-1:1]}; alu_cout = 1'b0; end
      default: begin result = '0; alu_cout = 1'b0; end
    endcase
  endtask

  task automatic check(input string req, input logic [7:0] exp);
    n_checks++;
    if (ccr !== exp) begin
      n_fail++;
      $display("FAIL %s: ccr=%b expected=%b", req, ccr, exp);
    end
  endtask

  task automatic int_op(input logic [2:0] cls, input logic [W-1:0] a,
                        input logic [W-1:0] b, input logic valid, input logic xfer);
    @(negedge clk);
    op_class = cls; opnd_a = a; opnd_b = b;
    alu_model(cls, a, b);
    op_valid = valid; bus_xfer = xfer;
    @(negedge clk);
    op_valid = 1'b0; bus_xfer = 1'b0;
  endtask

  task automatic fp_op(input logic [W-1:0] r, input logic fixed, input logic ovf,
                       input logic [3:0] st);
    @(negedge clk);
    op_class = 3'd6; result = r; fp_fixed = fixed; fp_fix_ovf = ovf;
    fp_status = st; op_valid = 1'b1; bus_xfer = 1'b0;
    @(negedge clk);
    op_valid = 1'b0; fp_fixed = 1'b0; fp_fix_ovf = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: ran=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset held", 8'h00);

    for (int i = 0; i < 18; i++) begin
      int_op(VEC[i][70:68], VEC[i][67:36], VEC[i][35:4], 1'b1, 1'b0);
      check($sformatf("R2/R3/R4/R5/R8/R11 vector %0d", i), {4'b0000, VEC[i][3:0]});
    end

    // set carry, then floating-point op without fixed result
    int_op(3'd0, 32'hFFFFFFFF, 32'h00000001, 1'b1, 1'b0);
    check("R2 carry set before fp", 8'h05);
    fp_op(32'h00000000, 1'b0, 1'b1, 4'b1010);
    check("R6 R7 fp keeps C and V, loads status", 8'hA5);
    fp_op(32'h80000000, 1'b1, 1'b1, 4'b0101);
    check("R7 fp fixed result loads V", 8'h5B);
    fp_op(32'h00000010, 1'b1, 1'b0, 4'b0011);
    check("R7 fp fixed clears V", 8'h31);

    // bus transfer with strobe: nothing changes
    int_op(3'd0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b1);
    check("R9 bus transfer blocks update", 8'h31);
    // no strobe: nothing changes
    int_op(3'd1, 32'h00000003, 32'h00000005, 1'b0, 1'b0);
    check("R10 idle hold", 8'h31);
    // integer op keeps fp bits
    int_op(3'd0, 32'h7FFFFFFF, 32'h00000001, 1'b1, 1'b0);
    check("R11 int op keeps fp bits", 8'h3A);
    int_op(3'd3, 32'h00000003, 32'h00000000, 1'b1, 1'b0);
    check("R4 shr clears V", 8'h31);

    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule